// File: doc/BRIEF.md
# USB Endpoint Handshake and Data Toggle Unit

This block makes the per-endpoint decisions of a USB device controller. The packet layer sends it one decoded event per transaction: the token kind, the endpoint number, the received data PID, whether a buffer is ready, and whether the link runs at high speed. One cycle later the block returns the handshake to send and a strobe that either accepts or discards the data. It also keeps the DATA0/DATA1 sequence bit for each endpoint in each direction.

Each endpoint has a configuration word that holds both directions. Each direction has an endpoint type, a stall flag, a self-clearing sequence-reset bit and a test-only sequence-inhibit bit. Software changes the word through a write port and reads it back through the same endpoint select. A SETUP on a control endpoint clears the stall flags. A data packet that arrives with the wrong PID is treated as a duplicate: it is dropped silently but still acknowledged, so that the host stops resending it.

Top module: `usb_ep_handshake`

## Requirements
- R1: An OUT data packet is accepted when its PID bit (`ev_pid1`, 1 = DATA1) equals the endpoint's receive sequence bit. `data_accept` pulses and the sequence bit then becomes the inverse of the received PID. Each endpoint keeps its own bit.
- R2: An OUT data packet whose PID does not match the sequence bit, on an endpoint that is not stalled and has a buffer ready, gets `data_discard` and no `data_accept`. It is still answered with ACK (or NYET under the R7 rule), and the sequence bit does not change.
- R3: Writing 1 to a sequence-reset bit (bit 3 for receive, bit 8 for transmit) returns that bit to DATA0. The reset bit itself always reads back 0.
- R4: While the receive inhibit bit (bit 4) is 1, every OUT data packet is accepted, whatever its PID. After the inhibit bit is cleared, the PID is compared again.
- R5: A SETUP token (code 0) to an endpoint whose receive type (bits 1:0) is not control (0) is answered with STALL and nothing is accepted. The stall flags are left as they were.
- R6: An IN (1), OUT (2) or PING (3) token to an endpoint whose stall flag for that direction is set (bit 2 receive, bit 7 transmit) is answered with STALL (code 4), and the stall flag is left as it was.
- R7: On an endpoint that is not stalled, OUT and PING are answered with NAK (2) when no buffer is ready. An accepted or duplicate OUT is answered with NYET (3) when `ev_hs` is 1 and `ev_nxt_rdy` is 0, and with ACK (1) otherwise. PING with a buffer ready gets ACK.
- R8: A SETUP to a control endpoint is answered with ACK and accepted even when no buffer is ready. It clears both stall flags and sets both sequence bits to DATA1.
- R9: A single configuration write (fields: receive type 1:0, receive stall 2, receive reset 3, receive inhibit 4, transmit type 6:5, transmit stall 7, transmit reset 8, transmit inhibit 9) can set both stall flags, and both take effect for the next event. `cfg_rdata` returns the word of `cfg_ep` one cycle after `cfg_ep` is presented.
- R10: An IN token to an endpoint that is not stalled and has a buffer ready is answered with DATA (code 5), with `rsp_data1` equal to the transmit sequence bit. A host-ACK event (token code 4) flips that bit and produces no response.
- R11: After synchronous reset every configuration word reads 0, every sequence bit is DATA0, and no response, accept or discard is driven.
- R12: Responses appear one clock after the event, with `rsp_valid` set. When `rsp_valid` is 0, neither `data_accept` nor `data_discard` is driven, and `data_accept` is never set together with a STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | EP_W | Endpoint selected for write and readback |
| cfg_wdata | input | 10 | Configuration word to write |
| cfg_rdata | output | 10 | Registered readback of the selected endpoint |
| ev_valid | input | 1 | Event strobe |
| ev_ep | input | EP_W | Endpoint addressed by the token |
| ev_tok | input | 3 | Token: 0 SETUP, 1 IN, 2 OUT, 3 PING, 4 host ACK |
| ev_pid1 | input | 1 | Received data PID is DATA1 |
| ev_buf_rdy | input | 1 | Buffer ready for this transaction |
| ev_hs | input | 1 | Link runs at high speed |
| ev_nxt_rdy | input | 1 | A further receive buffer is ready |
| rsp_valid | output | 1 | A handshake response is present |
| rsp_code | output | 3 | 1 ACK, 2 NAK, 3 NYET, 4 STALL, 5 DATA |
| rsp_data1 | output | 1 | PID to send with DATA is DATA1 |
| data_accept | output | 1 | Received data is passed upward |
| data_discard | output | 1 | Received data is dropped as a duplicate |

## Verification
The hardest state to reach is a duplicate packet: the sequence bit has to be ahead of the PID the host sends. The stimulus gets there by sending the same DATA0 packet twice in a row. It also sends a mismatched PID at high speed with no next buffer, so that a discarded packet is seen to receive NYET. The sequence-reset test stalls the endpoint first while its bits are at DATA1, so that clearing the stall together with the reset shows a real return to DATA0.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [2:0] {
    TK_SETUP = 3'd0, TK_IN = 3'd1, TK_OUT = 3'd2, TK_PING = 3'd3, TK_HACK = 3'd4
  } tok_e;

  typedef enum logic [2:0] {
    HS_NONE = 3'd0, HS_ACK = 3'd1, HS_NAK = 3'd2, HS_NYET = 3'd3,
    HS_STALL = 3'd4, HS_DATA = 3'd5
  } hs_e;

  localparam logic [1:0] EPT_CTRL = 2'd0;

  localparam int CFG_W  = 10;
  localparam int B_OTYP = 0;
  localparam int B_OSTL = 2;
  localparam int B_ORST = 3;
  localparam int B_OINH = 4;
  localparam int B_ITYP = 5;
  localparam int B_ISTL = 7;
  localparam int B_IRST = 8;
  localparam int B_IINH = 9;
endpackage

// File: rtl/usb_ep_cfg.sv
module usb_ep_cfg
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [EP_W-1:0]  wr_ep,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [EP_W-1:0]  rd_ep,
  output logic [CFG_W-1:0] rd_data,
  input  logic             clr_en,
  input  logic [EP_W-1:0]  clr_ep,
  output logic [1:0]       typ_o [NUM_EP],
  output logic [1:0]       typ_i [NUM_EP],
  output logic [NUM_EP-1:0] stall_o,
  output logic [NUM_EP-1:0] stall_i,
  output logic [NUM_EP-1:0] inh_o,
  output logic [NUM_EP-1:0] inh_i
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stall_o <= '0;
      stall_i <= '0;
      inh_o   <= '0;
      inh_i   <= '0;
      for (int i = 0; i < NUM_EP; i++) begin
        typ_o[i] <= EPT_CTRL;
        typ_i[i] <= EPT_CTRL;
      end
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (wr_en && wr_ep == EP_W'(i)) begin
          typ_o[i]   <= wr_data[B_OTYP +: 2];
          stall_o[i] <= wr_data[B_OSTL];
          inh_o[i]   <= wr_data[B_OINH];
          typ_i[i]   <= wr_data[B_ITYP +: 2];
          stall_i[i] <= wr_data[B_ISTL];
          inh_i[i]   <= wr_data[B_IINH];
        end else if (clr_en && clr_ep == EP_W'(i)) begin
          stall_o[i] <= 1'b0;
          stall_i[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data                <= '0;
      rd_data[B_OTYP +: 2]   <= typ_o[rd_ep];
      rd_data[B_OSTL]        <= stall_o[rd_ep];
      rd_data[B_OINH]        <= inh_o[rd_ep];
      rd_data[B_ITYP +: 2]   <= typ_i[rd_ep];
      rd_data[B_ISTL]        <= stall_i[rd_ep];
      rd_data[B_IINH]        <= inh_i[rd_ep];
    end
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_stall_chk
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !(clr_en && clr_ep == EP_W'(g)))
        |=> ($stable(stall_o[g]) && $stable(stall_i[g])));
  end
endmodule

// File: rtl/usb_ep_seq.sv
module usb_ep_seq #(
  parameter int NUM_EP = 4,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rs_en,
  input  logic [EP_W-1:0]   rs_ep,
  input  logic              rs_o,
  input  logic              rs_i,
  input  logic [EP_W-1:0]   up_ep,
  input  logic              up_o_we,
  input  logic              up_o_val,
  input  logic              up_i_we,
  input  logic              up_i_val,
  output logic [NUM_EP-1:0] tog_o,
  output logic [NUM_EP-1:0] tog_i
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tog_o <= '0;
      tog_i <= '0;
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (rs_en && rs_o && rs_ep == EP_W'(i))
          tog_o[i] <= 1'b0;
        else if (up_o_we && up_ep == EP_W'(i))
          tog_o[i] <= up_o_val;
        if (rs_en && rs_i && rs_ep == EP_W'(i))
          tog_i[i] <= 1'b0;
        else if (up_i_we && up_ep == EP_W'(i))
          tog_i[i] <= up_i_val;
      end
    end
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_tog_chk
    // R10
    tog_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!rs_en && !(up_i_we && up_ep == EP_W'(g))) |=> $stable(tog_i[g]));
    // R2
    tog_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!rs_en && !(up_o_we && up_ep == EP_W'(g))) |=> $stable(tog_o[g]));
  end
endmodule

// File: rtl/usb_ep_decide.sv
module usb_ep_decide
  import usb_ep_pkg::*;
(
  input  logic       ev_en,
  input  tok_e       tok,
  input  logic       pid1,
  input  logic       buf_rdy,
  input  logic       hs,
  input  logic       nxt_rdy,
  input  logic [1:0] typ_o,
  input  logic       stall_o,
  input  logic       stall_i,
  input  logic       inh_o,
  input  logic       tog_o,
  input  logic       tog_i,
  output logic       rsp_v,
  output hs_e        code,
  output logic       data1,
  output logic       acc,
  output logic       dis,
  output logic       clr_stall,
  output logic       o_we,
  output logic       o_val,
  output logic       i_we,
  output logic       i_val
);
  logic ok_hs;
  assign ok_hs = (hs && !nxt_rdy) ? 1'b1 : 1'b0;

  always_comb begin
    rsp_v = 1'b0; code = HS_NONE; data1 = 1'b0; acc = 1'b0; dis = 1'b0;
    clr_stall = 1'b0; o_we = 1'b0; o_val = 1'b0; i_we = 1'b0; i_val = 1'b0;
    if (ev_en) begin
      unique case (tok)
        TK_SETUP: begin
          rsp_v = 1'b1;
          if (typ_o == EPT_CTRL) begin
            code = HS_ACK; acc = 1'b1; clr_stall = 1'b1;
            o_we = 1'b1; o_val = 1'b1; i_we = 1'b1; i_val = 1'b1;
          end else begin
            code = HS_STALL;
          end
        end
        TK_OUT: begin
          rsp_v = 1'b1;
          if (stall_o)       code = HS_STALL;
          else if (!buf_rdy) code = HS_NAK;
          else begin
            code = ok_hs ? HS_NYET : HS_ACK;
            if (inh_o || pid1 == tog_o) begin
              acc = 1'b1; o_we = 1'b1; o_val = ~pid1;
            end else begin
              dis = 1'b1;
            end
          end
        end
        TK_PING: begin
          rsp_v = 1'b1;
          if (stall_o)      code = HS_STALL;
          else if (buf_rdy) code = HS_ACK;
          else              code = HS_NAK;
        end
        TK_IN: begin
          rsp_v = 1'b1;
          if (stall_i)      code = HS_STALL;
          else if (buf_rdy) begin code = HS_DATA; data1 = tog_i; end
          else              code = HS_NAK;
        end
        TK_HACK: begin
          i_we = 1'b1; i_val = ~tog_i;
        end
        default: rsp_v = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [EP_W-1:0]  cfg_ep,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             ev_valid,
  input  logic [EP_W-1:0]  ev_ep,
  input  logic [2:0]       ev_tok,
  input  logic             ev_pid1,
  input  logic             ev_buf_rdy,
  input  logic             ev_hs,
  input  logic             ev_nxt_rdy,
  output logic             rsp_valid,
  output logic [2:0]       rsp_code,
  output logic             rsp_data1,
  output logic             data_accept,
  output logic             data_discard
);
  logic [1:0]        typ_o [NUM_EP];
  logic [1:0]        typ_i [NUM_EP];
  logic [NUM_EP-1:0] stall_o, stall_i, inh_o, inh_i, tog_o, tog_i;

  logic d_v, d_data1, d_acc, d_dis, d_clr, d_owe, d_oval, d_iwe, d_ival;
  hs_e  d_code;

  usb_ep_cfg #(.NUM_EP(NUM_EP), .EP_W(EP_W)) cfg_i (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_ep(cfg_ep), .wr_data(cfg_wdata),
    .rd_ep(cfg_ep), .rd_data(cfg_rdata),
    .clr_en(d_clr), .clr_ep(ev_ep),
    .typ_o(typ_o), .typ_i(typ_i),
    .stall_o(stall_o), .stall_i(stall_i), .inh_o(inh_o), .inh_i(inh_i)
  );

  usb_ep_seq #(.NUM_EP(NUM_EP), .EP_W(EP_W)) seq_i (
    .clk(clk), .rst(rst),
    .rs_en(cfg_we), .rs_ep(cfg_ep),
    .rs_o(cfg_wdata[B_ORST]), .rs_i(cfg_wdata[B_IRST]),
    .up_ep(ev_ep),
    .up_o_we(d_owe), .up_o_val(d_oval), .up_i_we(d_iwe), .up_i_val(d_ival),
    .tog_o(tog_o), .tog_i(tog_i)
  );

  usb_ep_decide dec_i (
    .ev_en(ev_valid), .tok(tok_e'(ev_tok)), .pid1(ev_pid1),
    .buf_rdy(ev_buf_rdy), .hs(ev_hs), .nxt_rdy(ev_nxt_rdy),
    .typ_o(typ_o[ev_ep]), .stall_o(stall_o[ev_ep]), .stall_i(stall_i[ev_ep]),
    .inh_o(inh_o[ev_ep]), .tog_o(tog_o[ev_ep]), .tog_i(tog_i[ev_ep]),
    .rsp_v(d_v), .code(d_code), .data1(d_data1), .acc(d_acc), .dis(d_dis),
    .clr_stall(d_clr), .o_we(d_owe), .o_val(d_oval), .i_we(d_iwe), .i_val(d_ival)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0; rsp_code <= 3'd0; rsp_data1 <= 1'b0;
      data_accept <= 1'b0; data_discard <= 1'b0;
    end else begin
      rsp_valid    <= d_v;
      rsp_code     <= d_code;
      rsp_data1    <= d_data1;
      data_accept  <= d_acc;
      data_discard <= d_dis;
    end
  end

  // R12
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!data_accept && !data_discard));
  // R12
  no_accept_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == HS_STALL) |-> !data_accept);
  // R2
  discard_acked_chk: assert property (@(posedge clk) disable iff (rst)
    data_discard |-> (!data_accept && (rsp_code == HS_ACK || rsp_code == HS_NYET)));
  // R12
  resp_follows_event_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !rsp_valid);
endmodule

// File: tb/usb_ep_handshake_tb_top.sv
module usb_ep_handshake_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NEP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_ep = '0;
  logic [9:0] cfg_wdata = '0;
  logic [9:0] cfg_rdata;
  logic       ev_valid = 1'b0;
  logic [1:0] ev_ep = '0;
  logic [2:0] ev_tok = '0;
  logic       ev_pid1 = 1'b0, ev_buf_rdy = 1'b0, ev_hs = 1'b0, ev_nxt_rdy = 1'b0;
  logic       rsp_valid, rsp_data1, data_accept, data_discard;
  logic [2:0] rsp_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_handshake #(.NUM_EP(NEP)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ev_valid(ev_valid), .ev_ep(ev_ep), .ev_tok(ev_tok),
    .ev_pid1(ev_pid1), .ev_buf_rdy(ev_buf_rdy), .ev_hs(ev_hs), .ev_nxt_rdy(ev_nxt_rdy),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data1(rsp_data1),
    .data_accept(data_accept), .data_discard(data_discard)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] ep;
    logic [2:0] tok;
    logic       pid;
    logic       bf;
    logic       hs;
    logic       nx;
    logic [9:0] wd;
    logic       xv;
    logic [2:0] xc;
    logic       xd;
    logic       xa;
    logic       xx;
    logic [7:0] req;
  } vec_t;

  // tok: 0 SETUP 1 IN 2 OUT 3 PING 4 HACK; code: 1 ACK 2 NAK 3 NYET 4 STALL 5 DATA
  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    '{1'b1,2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,10'h042,1'b0,3'd0,1'b0,1'b0,1'b0,8'd9},  // R9 ep1 bulk
    '{1'b0,2'd1,3'd2,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd1},  // R1
    '{1'b0,2'd1,3'd2,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b0,1'b1,8'd2},  // R2 duplicate
    '{1'b0,2'd1,3'd2,1'b1,1'b1,1'b1,1'b0,10'h000,1'b1,3'd3,1'b0,1'b1,1'b0,8'd7},  // R7 NYET
    '{1'b0,2'd1,3'd2,1'b0,1'b0,1'b0,1'b0,10'h000,1'b1,3'd2,1'b0,1'b0,1'b0,8'd7},  // R7 NAK
    '{1'b0,2'd1,3'd2,1'b0,1'b1,1'b1,1'b1,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd1},  // R1
    '{1'b0,2'd1,3'd2,1'b0,1'b1,1'b1,1'b0,10'h000,1'b1,3'd3,1'b0,1'b0,1'b1,8'd2},  // R2 dup NYET
    '{1'b0,2'd1,3'd3,1'b0,1'b0,1'b0,1'b0,10'h000,1'b1,3'd2,1'b0,1'b0,1'b0,8'd7},  // R7 PING NAK
    '{1'b0,2'd1,3'd3,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b0,1'b0,8'd7},  // R7 PING ACK
    '{1'b0,2'd1,3'd1,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd5,1'b0,1'b0,1'b0,8'd10}, // R10 DATA0
    '{1'b0,2'd1,3'd4,1'b0,1'b0,1'b0,1'b0,10'h000,1'b0,3'd0,1'b0,1'b0,1'b0,8'd10}, // R10 host ack
    '{1'b0,2'd1,3'd1,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd5,1'b1,1'b0,1'b0,8'd10}, // R10 DATA1
    '{1'b0,2'd1,3'd1,1'b0,1'b0,1'b0,1'b0,10'h000,1'b1,3'd2,1'b0,1'b0,1'b0,8'd7},  // R7 IN NAK
    '{1'b0,2'd1,3'd0,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd5},  // R5
    '{1'b1,2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,10'h0C6,1'b0,3'd0,1'b0,1'b0,1'b0,8'd9},  // R9 both stalls
    '{1'b0,2'd1,3'd2,1'b1,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd6},  // R6
    '{1'b0,2'd1,3'd1,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd6},  // R6
    '{1'b0,2'd1,3'd3,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd6},  // R6
    '{1'b0,2'd1,3'd0,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd5},  // R5
    '{1'b0,2'd1,3'd2,1'b1,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd6},  // R6 still
    '{1'b1,2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,10'h14A,1'b0,3'd0,1'b0,1'b0,1'b0,8'd3},  // R3 resets
    '{1'b0,2'd1,3'd2,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd3},  // R3
    '{1'b0,2'd1,3'd1,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd5,1'b0,1'b0,1'b0,8'd3},  // R3
    '{1'b1,2'd0,3'd0,1'b0,1'b0,1'b0,1'b0,10'h084,1'b0,3'd0,1'b0,1'b0,1'b0,8'd9},  // R9 ep0 stall
    '{1'b0,2'd0,3'd2,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd6},  // R6
    '{1'b0,2'd0,3'd0,1'b0,1'b0,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd8},  // R8
    '{1'b0,2'd0,3'd2,1'b1,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd8},  // R8
    '{1'b0,2'd0,3'd1,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd5,1'b1,1'b0,1'b0,8'd8},  // R8
    '{1'b1,2'd2,3'd0,1'b0,1'b0,1'b0,1'b0,10'h052,1'b0,3'd0,1'b0,1'b0,1'b0,8'd4},  // R4 inhibit
    '{1'b0,2'd2,3'd2,1'b1,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd4},  // R4
    '{1'b0,2'd2,3'd2,1'b1,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd4},  // R4
    '{1'b1,2'd2,3'd0,1'b0,1'b0,1'b0,1'b0,10'h042,1'b0,3'd0,1'b0,1'b0,1'b0,8'd4},  // R4 off
    '{1'b0,2'd2,3'd2,1'b1,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b0,1'b1,8'd4},  // R4
    '{1'b0,2'd2,3'd2,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd1},  // R1
    '{1'b0,2'd3,3'd2,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd1}   // R1 other ep
  };

  task automatic do_write(input logic [1:0] ep, input logic [9:0] wd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ep = ep; cfg_wdata = wd;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic check_rd(input logic [1:0] ep, input logic [9:0] exp, input string req);
    @(negedge clk);
    cfg_ep = ep;
    @(negedge clk);
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s readback ep%0d actual %h expected %h", req, ep, cfg_rdata, exp);
    end
  endtask

  task automatic do_event(input vec_t v);
    @(negedge clk);
    ev_valid = 1'b1; ev_ep = v.ep; ev_tok = v.tok; ev_pid1 = v.pid;
    ev_buf_rdy = v.bf; ev_hs = v.hs; ev_nxt_rdy = v.nx;
    @(negedge clk);
    ev_valid = 1'b0;
    checks++;
    if (rsp_valid !== v.xv || (v.xv && (rsp_code !== v.xc || (v.xc == 3'd5 && rsp_data1 !== v.xd)))
        || data_accept !== v.xa || data_discard !== v.xx) begin
      errors++;
      $display("FAIL R%0d ep%0d tok%0d actual v%b c%0d d%b a%b x%b expected v%b c%0d d%b a%b x%b",
               v.req, v.ep, v.tok, rsp_valid, rsp_code, rsp_data1, data_accept, data_discard,
               v.xv, v.xc, v.xd, v.xa, v.xx);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    checks++;
    if (rsp_valid !== 1'b0 || data_accept !== 1'b0 || data_discard !== 1'b0) begin
      errors++;
      $display("FAIL R11 outputs after reset actual %b%b%b expected 000",
               rsp_valid, data_accept, data_discard);
    end
    for (int e = 0; e < NEP; e++) check_rd(2'(e), 10'h000, "R11");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) do_write(TBL[i].ep, TBL[i].wd);
      else           do_event(TBL[i]);
    end

    check_rd(2'd1, 10'h042, "R3");   // reset bits read 0, stalls cleared
    check_rd(2'd0, 10'h000, "R8");   // SETUP cleared both stall flags
    check_rd(2'd2, 10'h042, "R4");

    // R9: one write sets both stalls, both visible at once
    do_write(2'd3, 10'h084);
    check_rd(2'd3, 10'h084, "R9");
    do_event('{1'b0,2'd3,3'd2,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd9});
    do_event('{1'b0,2'd3,3'd1,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd4,1'b0,1'b0,1'b0,8'd9});
    check_rd(2'd3, 10'h084, "R6");

    // R12: no response in the cycle after the event ends
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 idle rsp_valid actual %b expected 0", rsp_valid);
    end

    // R11: reset mid-run clears configuration and sequence bits
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_rd(2'd1, 10'h000, "R11");
    check_rd(2'd3, 10'h000, "R11");
    do_event('{1'b0,2'd0,3'd1,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd5,1'b0,1'b0,1'b0,8'd11});
    do_event('{1'b0,2'd0,3'd2,1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,3'd1,1'b0,1'b1,1'b0,8'd11});

    finish_run();
  end
endmodule